// File: doc/BRIEF.md
# UART Interrupt Source and Mask Controller

This block keeps the interrupt state of a single UART channel. Four event sources (receive, error, transmit, modem) each latch a sticky bit in a source register when their one-cycle strobe arrives. A mask register hides selected sources, and a masked pending register holds the sources that are set and not hidden. A single level interrupt line is high while any masked pending bit is set.

The host changes the state through one write port. A select code picks the mask, the source register or the pending register. Writes to the source or pending register clear each bit that is written as 1. A clear through the pending register also removes the source bit. When the transmit FIFO is enabled, the block compares the incoming transmit FIFO fill count with a level taken from a 3-bit code in the FIFO configuration word. The level is that code times a step, and the step is fixed at elaboration by the channel number. While the count is at or below the level, the transmit source bit keeps being set.

All state is registered on the rising clock edge, including the interrupt line, so there is no combinational path from any input to the output.

Top module: `uirq_ctrl`

## Requirements
- R1: After reset, the source, mask and pending registers are all 0 and irq is 0.
- R2: A strobe on ev_rx, ev_err, ev_tx or ev_modem sets source bit 0, 1, 2 or 3 respectively at the next rising edge. The bit then stays set until it is cleared.
- R3: In every cycle, pend equals src_pend AND NOT mask, and both are updated at the same edge.
- R4: irq is 1 exactly when pend is non-zero.
- R5: wr_en with wr_sel = 0 loads wr_data into the mask register at the next edge.
- R6: wr_en with wr_sel = 1 clears every source bit where wr_data is 1 and leaves the other bits unchanged.
- R7: wr_en with wr_sel = 2 clears every source bit where wr_data is 1, whether or not that bit is masked. The matching pending bits go to 0 with it.
- R8: wr_en with wr_sel = 3 changes no register.
- R9: If a set and a host clear hit the same source bit in the same cycle, the bit ends up set.
- R10: While fifo_cfg bit 0 is 1, source bit 2 is set at the next edge whenever tx_count is less than or equal to the level. The level is the code in fifo_cfg bits 10:8 times the channel step.
- R11: The channel step is 32 for channel 0, 8 for channels 1 and 4, and 2 for channels 2 and 3. For any other channel the step is 0, which gives a level of 0.
- R12: While fifo_cfg bit 0 is 0, tx_count and the threshold code do not affect source bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_rx | input | 1 | Receive event strobe |
| ev_err | input | 1 | Error event strobe |
| ev_tx | input | 1 | Transmit event strobe |
| ev_modem | input | 1 | Modem event strobe |
| fifo_cfg | input | CFG_W | FIFO configuration word: bit 0 enables the FIFO, bits 10:8 hold the transmit threshold code |
| tx_count | input | CNT_W | Current transmit FIFO fill count |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Write target: 0 mask, 1 source clear, 2 pending clear, 3 none |
| wr_data | input | 4 | Host write data, one bit per source |
| src_pend | output | 4 | Source register |
| mask | output | 4 | Mask register |
| pend | output | 4 | Masked pending register |
| irq | output | 1 | Level interrupt output |

## Verification
The bench drives the threshold exactly at its boundary: a count equal to the level and a count one above it. It does this on three channel variants, including the one whose level is always 0. A comparison off by one or a wrong step would set or miss source bit 2 on one side of that boundary. It also strikes a set strobe and a host clear on the same bit in the same cycle. If the clear won, the event would be lost. It clears a masked bit through the pending register; a design that cleared only the pending copy would raise irq again as soon as the mask was lifted. Random cycles mix events, all four write selects and random counts, and each result is compared with a bench model.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int NSRC      = 4;
    localparam int BIT_RX    = 0;
    localparam int BIT_ERR   = 1;
    localparam int BIT_TX    = 2;
    localparam int BIT_MODEM = 3;

    typedef enum logic [1:0] {
        WS_MASK     = 2'd0,
        WS_SRC_CLR  = 2'd1,
        WS_PEND_CLR = 2'd2,
        WS_NONE     = 2'd3
    } wsel_e;

    typedef struct packed {
        logic [NSRC-1:0] src;
        logic [NSRC-1:0] mask;
        logic [NSRC-1:0] pend;
        logic            irq;
    } state_t;

    // Transmit threshold step per channel number.
    function automatic int unsigned tx_step(input int unsigned ch);
        case (ch)
            0:       return 32;
            1, 4:    return 8;
            2, 3:    return 2;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/uirq_tx_level.sv
module uirq_tx_level #(
    parameter int CFG_W    = 16,
    parameter int CNT_W    = 8,
    parameter int CHANNEL  = 1,
    parameter int EN_BIT   = 0,
    parameter int CODE_LSB = 8,
    parameter int CODE_W   = 3
) (
    input  logic [CFG_W-1:0] fifo_cfg,
    input  logic [CNT_W-1:0] tx_count,
    output logic             hit
);
    import uirq_pkg::*;

    localparam int unsigned STEP = tx_step(CHANNEL);
    localparam int PROD_W = CODE_W + 6;
    localparam int LVL_W  = ((CNT_W > PROD_W) ? CNT_W : PROD_W) + 1;

    logic [CODE_W-1:0] code;
    logic [LVL_W-1:0]  level;
    logic [LVL_W-1:0]  cnt_ext;

    always_comb begin
        code    = fifo_cfg[CODE_LSB +: CODE_W];
        level   = LVL_W'(code) * LVL_W'(STEP);
        cnt_ext = LVL_W'(tx_count);
        hit     = fifo_cfg[EN_BIT] && (cnt_ext <= level);
    end

endmodule

// File: rtl/uirq_src_next.sv
module uirq_src_next #(
    parameter int N = 4
) (
    input  logic [N-1:0] src_q,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] src_d
);
    // Per bit: a set in the same cycle as a clear keeps the bit.
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign src_d[i] = set_vec[i] | (src_q[i] & ~clr_vec[i]);
    end
endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl #(
    parameter int CFG_W   = 16,
    parameter int CNT_W   = 8,
    parameter int CHANNEL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_rx,
    input  logic             ev_err,
    input  logic             ev_tx,
    input  logic             ev_modem,
    input  logic [CFG_W-1:0] fifo_cfg,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [3:0]       wr_data,
    output logic [3:0]       src_pend,
    output logic [3:0]       mask,
    output logic [3:0]       pend,
    output logic             irq
);
    import uirq_pkg::*;

    state_t          st_q, st_d;
    logic            thr_hit;
    logic [NSRC-1:0] set_vec, clr_vec, src_nxt;
    wsel_e           wsel;

    uirq_tx_level #(
        .CFG_W(CFG_W), .CNT_W(CNT_W), .CHANNEL(CHANNEL),
        .EN_BIT(0), .CODE_LSB(8), .CODE_W(3)
    ) u_lvl (
        .fifo_cfg(fifo_cfg),
        .tx_count(tx_count),
        .hit     (thr_hit)
    );

    uirq_src_next #(.N(NSRC)) u_nxt (
        .src_q  (st_q.src),
        .set_vec(set_vec),
        .clr_vec(clr_vec),
        .src_d  (src_nxt)
    );

    always_comb begin
        wsel               = wsel_e'(wr_sel);
        set_vec            = '0;
        set_vec[BIT_RX]    = ev_rx;
        set_vec[BIT_ERR]   = ev_err;
        set_vec[BIT_TX]    = ev_tx | thr_hit;
        set_vec[BIT_MODEM] = ev_modem;
        clr_vec = (wr_en && (wsel == WS_SRC_CLR || wsel == WS_PEND_CLR))
                  ? wr_data : '0;

        st_d      = st_q;
        st_d.src  = src_nxt;
        if (wr_en && wsel == WS_MASK) begin
            st_d.mask = wr_data;
        end
        st_d.pend = st_d.src & ~st_d.mask;
        st_d.irq  = |st_d.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_pend = st_q.src;
    assign mask     = st_q.mask;
    assign pend     = st_q.pend;
    assign irq      = st_q.irq;

endmodule

// File: rtl/uirq_ctrl_chk.sv
module uirq_ctrl_chk #(
    parameter int CFG_W = 16,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ev_rx,
    input logic             ev_err,
    input logic             ev_tx,
    input logic             ev_modem,
    input logic [CFG_W-1:0] fifo_cfg,
    input logic [CNT_W-1:0] tx_count,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [3:0]       wr_data,
    input logic [3:0]       src_pend,
    input logic [3:0]       mask,
    input logic [3:0]       pend,
    input logic             irq
);
    logic [3:0] evs;
    assign evs = {ev_modem, ev_tx, ev_err, ev_rx};

    // R1: registers are clear when reset is released
    p_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (src_pend == 4'd0 && mask == 4'd0 && pend == 4'd0 && !irq));

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((src_pend & $past(evs)) == $past(evs)));

    p_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pend == (src_pend & ~mask));

    p_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (pend != 4'd0));

    p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> mask == $past(wr_data));

    p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1)
        |=> ((src_pend & $past(wr_data & ~evs) & 4'b1011) == 4'd0));

    p_pclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2)
        |=> ((src_pend & $past(wr_data & ~evs) & 4'b1011) == 4'd0));

    p_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) |=> $stable(mask));

    p_setwins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx && wr_en && wr_sel != 2'd0 && wr_data[0]) |=> src_pend[0]);

    p_thr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cfg[0] && tx_count == '0) |=> src_pend[2]);

    p_fifo_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_cfg[0] && !ev_tx && !src_pend[2]) |=> !src_pend[2]);

endmodule

bind uirq_ctrl uirq_ctrl_chk #(.CFG_W(CFG_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_rx(ev_rx), .ev_err(ev_err), .ev_tx(ev_tx),
    .ev_modem(ev_modem), .fifo_cfg(fifo_cfg), .tx_count(tx_count),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .src_pend(src_pend),
    .mask(mask), .pend(pend), .irq(irq)
);

// File: tb/sim_uirq_ctrl.sv
`timescale 1ns/1ps
module sim_uirq_ctrl;
    localparam int CFG_W = 16;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_rx = 0, ev_err = 0, ev_tx = 0, ev_modem = 0;
    logic [CFG_W-1:0] fifo_cfg = '0;
    logic [CNT_W-1:0] tx_count = '0;
    logic wr_en = 0;
    logic [1:0] wr_sel = 2'd3;
    logic [3:0] wr_data = 4'd0;

    logic [3:0] src0, mask0, pend0, srcA, maskA, pendA, srcB, maskB, pendB;
    logic irq0, irqA, irqB;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [3:0] m_src0 = 0, m_srcA = 0, m_srcB = 0, m_mask = 0;

    always #4 clk = ~clk;   // 125 MHz

    uirq_ctrl #(.CFG_W(CFG_W), .CNT_W(CNT_W), .CHANNEL(1)) u0 (
        .clk, .rst_n, .ev_rx, .ev_err, .ev_tx, .ev_modem, .fifo_cfg, .tx_count,
        .wr_en, .wr_sel, .wr_data, .src_pend(src0), .mask(mask0), .pend(pend0), .irq(irq0));
    uirq_ctrl #(.CFG_W(CFG_W), .CNT_W(CNT_W), .CHANNEL(0)) u_ch0 (
        .clk, .rst_n, .ev_rx, .ev_err, .ev_tx, .ev_modem, .fifo_cfg, .tx_count,
        .wr_en, .wr_sel, .wr_data, .src_pend(srcA), .mask(maskA), .pend(pendA), .irq(irqA));
    uirq_ctrl #(.CFG_W(CFG_W), .CNT_W(CNT_W), .CHANNEL(7)) u_ch7 (
        .clk, .rst_n, .ev_rx, .ev_err, .ev_tx, .ev_modem, .fifo_cfg, .tx_count,
        .wr_en, .wr_sel, .wr_data, .src_pend(srcB), .mask(maskB), .pend(pendB), .irq(irqB));

    function automatic int unsigned step_of(int ch);
        if (ch == 0) return 32;
        if (ch == 1 || ch == 4) return 8;
        if (ch == 2 || ch == 3) return 2;
        return 0;
    endfunction

    function automatic logic thr(int ch, logic [CFG_W-1:0] cfg, logic [CNT_W-1:0] cnt);
        return cfg[0] && (int'(cnt) <= int'(cfg[10:8]) * int'(step_of(ch)));
    endfunction

    function automatic logic [3:0] next_src(logic [3:0] cur, logic hit);
        logic [3:0] setv, clrv;
        setv = {ev_modem, ev_tx | hit, ev_err, ev_rx};
        clrv = (wr_en && (wr_sel == 2'd1 || wr_sel == 2'd2)) ? wr_data : 4'd0;
        return (cur & ~clrv) | setv;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk({tag, " src ch1"}, 32'(src0), 32'(m_src0));
        chk({tag, " mask (R5)"}, 32'(mask0), 32'(m_mask));
        chk({tag, " pend (R3)"}, 32'(pend0), 32'(m_src0 & ~m_mask));
        chk({tag, " irq (R4)"}, 32'(irq0), 32'(|(m_src0 & ~m_mask)));
        chk({tag, " src ch0 (R11)"}, 32'(srcA), 32'(m_srcA));
        chk({tag, " src ch7 (R11)"}, 32'(srcB), 32'(m_srcB));
    endtask

    // Inputs are set at a negedge; this advances one edge and checks.
    task automatic cycle(string tag);
        logic [3:0] n0, nA, nB, nm;
        n0 = next_src(m_src0, thr(1, fifo_cfg, tx_count));
        nA = next_src(m_srcA, thr(0, fifo_cfg, tx_count));
        nB = next_src(m_srcB, thr(7, fifo_cfg, tx_count));
        nm = (wr_en && wr_sel == 2'd0) ? wr_data : m_mask;
        @(posedge clk);
        @(negedge clk);
        m_src0 = n0; m_srcA = nA; m_srcB = nB; m_mask = nm;
        compare_all(tag);
    endtask

    task automatic idle();
        ev_rx = 0; ev_err = 0; ev_tx = 0; ev_modem = 0;
        wr_en = 0; wr_sel = 2'd3; wr_data = 4'd0;
    endtask

    task automatic host(logic [1:0] sel, logic [3:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
    endtask

    initial begin
        void'($urandom(32'h5EED_0001));
        repeat (3) @(negedge clk);
        compare_all("R1 in reset");
        rst_n = 1;
        compare_all("R1 after release");
        chk("R1 irq low", 32'(irq0), 32'd0);

        // FIFO disabled, full count: only strobes set bits
        tx_count = 8'hFF;
        idle(); ev_rx = 1;    cycle("R2 rx bit0");
        chk("R2 rx bit0 set", 32'(src0[0]), 32'd1);
        idle(); ev_err = 1;   cycle("R2 err bit1");
        idle(); ev_tx = 1;    cycle("R2 tx bit2");
        idle(); ev_modem = 1; cycle("R2 modem bit3");
        chk("R2 all four set", 32'(src0), 32'hF);
        idle(); cycle("R2 sticky");
        idle(); host(2'd0, 4'b0101); cycle("R5 mask write");
        chk("R4 irq with partial mask", 32'(irq0), 32'd1);
        idle(); host(2'd3, 4'b1111); cycle("R8 select 3 no effect");
        chk("R8 src unchanged", 32'(src0), 32'hF);
        idle(); host(2'd1, 4'b0011); cycle("R6 source clear");
        chk("R6 bits 0,1 cleared", 32'(src0), 32'b1100);
        idle(); host(2'd2, 4'b0100); cycle("R7 pending clear of masked bit");
        chk("R7 masked source cleared", 32'(src0), 32'b1000);
        idle(); host(2'd0, 4'b0000); cycle("R7 unmask keeps bit2 clear");
        chk("R7 pend after unmask", 32'(pend0), 32'b1000);
        idle(); ev_err = 1; host(2'd2, 4'b1010); cycle("R9 set wins");
        chk("R9 bit1 kept", 32'(src0), 32'b0010);
        idle(); host(2'd1, 4'hF); cycle("R6 clear all");
        chk("R4 irq low when empty", 32'(irq0), 32'd0);

        // Threshold code 3: levels 24 (ch1), 96 (ch0), 0 (ch7)
        fifo_cfg = 16'h0301; tx_count = 8'd24;
        idle(); cycle("R10 count at level");
        chk("R10 ch1 count=24 sets", 32'(src0[2]), 32'd1);
        chk("R11 ch7 level 0 no set", 32'(srcB[2]), 32'd0);
        tx_count = 8'd25; idle(); host(2'd1, 4'hF); cycle("R10 clear above level");
        idle(); cycle("R10 one above level");
        chk("R10 ch1 count=25 clear", 32'(src0[2]), 32'd0);
        chk("R11 ch0 count=25 sets", 32'(srcA[2]), 32'd1);
        tx_count = 8'd97; idle(); host(2'd1, 4'hF); cycle("R11 clear");
        idle(); cycle("R11 ch0 above 96");
        chk("R11 ch0 count=97 clear", 32'(srcA[2]), 32'd0);
        tx_count = 8'd0; idle(); cycle("R11 zero count");
        chk("R11 ch7 count=0 sets", 32'(srcB[2]), 32'd1);
        fifo_cfg = 16'h0700; idle(); host(2'd1, 4'hF); cycle("R12 disabled clear");
        idle(); cycle("R12 disabled zero count");
        chk("R12 no tx set when disabled", 32'(src0[2]), 32'd0);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            ev_rx    = ($urandom % 6) == 0;
            ev_err   = ($urandom % 8) == 0;
            ev_tx    = ($urandom % 8) == 0;
            ev_modem = ($urandom % 8) == 0;
            wr_en    = ($urandom % 2) == 0;
            wr_sel   = 2'($urandom);
            wr_data  = 4'($urandom);
            fifo_cfg = 16'($urandom) & 16'h0701;
            tx_count = 8'($urandom);
            cycle("R2/R6/R7/R9/R10/R12 random");
        end
        idle();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule